// File: doc/BRIEF.md
# Skewed Shared-Memory Access Sequencer

This block lets four processing elements (PEs) share one data memory without arbitration. The PEs run skewed in time, so only one of them owns the memory in any memory cycle. A sample interval is split into 24 PE time slots. Each PE slot is split into two memory-cycle subslots, which gives 48 memory cycles per sample. In every subslot the sequencer looks up one entry of a small schedule table and acts on it. The entry selects the owning PE, the memory address, and whether that cycle is a write or a read. If its valid bit is clear, the subslot belongs to an idle PE and no memory strobe is issued.

On a write subslot, the memory write data is taken from the result port of the selected PE. On a read subslot, the word the memory returns one cycle later is captured into the selected PE's operand register, and that PE's load strobe is pulsed. The schedule is arranged so that each PE writes its result first and then fetches fresh operands, and so that a producer on PE i hands its output to a consumer on PE (i+1) mod 4. The table is filled only while the sequencer is idle. A pulse on `sample_start` begins an interval. A `stop` pulse ends the run.

Top module: `skew_mem_seq`

## Requirements
- R1: Out of reset the sequencer is idle. `mem_we`, `mem_re` and `pe_load` are all 0, every operand register is 0, and every table entry is invalid.
- R2: A `sample_start` pulse without `stop` makes the sequencer run from slot 0 in the next cycle. After that it moves on by one slot per clock.
- R3: After slot 47 (the last of the 48 slots) the slot counter returns to slot 0 and keeps running.
- R4: In a running slot whose entry is valid, a write bit of 1 drives `mem_we`=1 and a write bit of 0 drives `mem_re`=1. `mem_addr` equals the entry address. Both strobes are never high together.
- R5: In a slot whose entry has valid=0 (an idle PE), both memory strobes stay 0.
- R6: During a write slot, `mem_wdata` equals the `pe_result` word of the PE in the entry, where PE p occupies bits [16p+15:16p].
- R7: `mem_rdata` is sampled in the cycle after a read strobe. In the cycle after that, the selected PE's operand word, at bits [16p+15:16p] of `pe_operand`, holds that data, and `pe_load` bit p is high for that one cycle only. At most one `pe_load` bit is ever high.
- R8: A table write (`tbl_we` with `tbl_idx` < 48) takes effect only while the sequencer is idle. A table write during a run is ignored.
- R9: A `stop` pulse makes the sequencer idle from the next cycle, with no memory strobes. `stop` takes priority over a `sample_start` in the same cycle.
- R10: A `sample_start` during a run restarts the interval at slot 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_start | input | 1 | Starts or restarts a sample interval at slot 0 |
| stop | input | 1 | Returns the sequencer to idle |
| tbl_we | input | 1 | Schedule table write enable (honoured only while idle) |
| tbl_idx | input | 6 | Table entry index (slot number) |
| tbl_valid | input | 1 | Entry valid bit (0 = idle PE slot) |
| tbl_write | input | 1 | Entry direction (1 = write, 0 = read) |
| tbl_pe | input | 2 | Entry PE index |
| tbl_addr | input | 6 | Entry memory address |
| pe_result | input | 64 | Result words of the four PEs, PE p at [16p+15:16p] |
| pe_operand | output | 64 | Operand registers of the four PEs, PE p at [16p+15:16p] |
| pe_load | output | 4 | One-cycle operand load strobe per PE |
| mem_addr | output | 6 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_re` |

## Verification
A wrong slot count or wrong wrap point shows up in the cycle it happens. The address or strobe at the ports no longer matches the table entry for that cycle's slot, and every slot after it is off as well. A wrong captured PE index or a wrong read pipeline depth shows two cycles after the read strobe, because `pe_load` rises on the wrong bit or in the wrong cycle. A table that accepts a write during a run is only seen at the next pass over that slot. So the bench rewrites a slot during a run and then reruns that slot.

// File: rtl/skew_seq_pkg.sv
package skew_seq_pkg;

    localparam int NUM_PE = 4;
    localparam int PE_W   = $clog2(NUM_PE);
    localparam int ADDR_W = 6;

    typedef struct packed {
        logic              valid;
        logic              is_wr;
        logic [PE_W-1:0]   pe;
        logic [ADDR_W-1:0] addr;
    } sched_ent_t;

    function automatic logic [NUM_PE-1:0] pe_onehot(input logic [PE_W-1:0] p);
        logic [NUM_PE-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/seq_slot_counter.sv
module seq_slot_counter #(
    parameter int SLOTS  = 48,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    output logic              running,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            running <= 1'b0;
            slot    <= '0;
        end else if (start) begin
            running <= 1'b1;
            slot    <= '0;
        end else if (running) begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    a_r2_start: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> (running && slot == '0));
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (running && !start && !stop && slot != LAST) |=> (slot == SLOT_W'($past(slot) + 1'b1)));
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (running && !start && !stop && slot == LAST) |=> (running && slot == '0));
    a_r9_stop: assert property (@(posedge clk) disable iff (rst)
        stop |=> !running);

endmodule

// File: rtl/seq_sched_table.sv
module seq_sched_table
    import skew_seq_pkg::*;
#(
    parameter int SLOTS  = 48,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  sched_ent_t        wr_ent,
    input  logic [SLOT_W-1:0] rd_idx,
    output sched_ent_t        rd_ent
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    sched_ent_t tbl [SLOTS];
    logic       wr_ok;

    assign wr_ok  = wr_en && !lock && (wr_idx <= LAST);
    assign rd_ent = (rd_idx <= LAST) ? tbl[rd_idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) tbl[i] <= '0;
        end else if (wr_ok) begin
            tbl[wr_idx] <= wr_ent;
        end
    end

    a_r8_locked: assert property (@(posedge clk) disable iff (rst)
        (lock && wr_en && wr_idx <= LAST) |=> (tbl[$past(wr_idx)] == $past(tbl[wr_idx])));

endmodule

// File: rtl/seq_operand_bank.sv
module seq_operand_bank
    import skew_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_fire,
    input  logic [PE_W-1:0]          rd_pe,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [NUM_PE*DATA_W-1:0] operand,
    output logic [NUM_PE-1:0]        load
);
    logic              pend;
    logic [PE_W-1:0]   pend_pe;
    logic [DATA_W-1:0] opr [NUM_PE];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            pend_pe <= '0;
            load    <= '0;
            for (int i = 0; i < NUM_PE; i++) opr[i] <= '0;
        end else begin
            pend    <= rd_fire;
            pend_pe <= rd_pe;
            load    <= pend ? pe_onehot(pend_pe) : '0;
            if (pend) opr[pend_pe] <= mem_rdata;
        end
    end

    for (genvar g = 0; g < NUM_PE; g++) begin : g_out
        assign operand[g*DATA_W +: DATA_W] = opr[g];
    end

    a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load));
    a_r7_after_read: assert property (@(posedge clk) disable iff (rst)
        (load != '0) |-> $past(rd_fire, 2));

endmodule

// File: rtl/skew_mem_seq.sv
module skew_mem_seq
    import skew_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PE_SLOTS = 24,
    parameter int SUBSLOTS = 2,
    parameter int SLOTS    = PE_SLOTS * SUBSLOTS,
    parameter int SLOT_W   = $clog2(SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_start,
    input  logic                     stop,
    input  logic                     tbl_we,
    input  logic [SLOT_W-1:0]        tbl_idx,
    input  logic                     tbl_valid,
    input  logic                     tbl_write,
    input  logic [PE_W-1:0]          tbl_pe,
    input  logic [ADDR_W-1:0]        tbl_addr,
    input  logic [NUM_PE*DATA_W-1:0] pe_result,
    output logic [NUM_PE*DATA_W-1:0] pe_operand,
    output logic [NUM_PE-1:0]        pe_load,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     mem_we,
    output logic                     mem_re,
    input  logic [DATA_W-1:0]        mem_rdata
);
    logic              running;
    logic [SLOT_W-1:0] slot;
    sched_ent_t        ent;
    sched_ent_t        wr_ent;
    logic [DATA_W-1:0] res_arr [NUM_PE];

    assign wr_ent = '{valid: tbl_valid, is_wr: tbl_write, pe: tbl_pe, addr: tbl_addr};

    seq_slot_counter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_cnt (
        .clk(clk), .rst(rst), .start(sample_start), .stop(stop),
        .running(running), .slot(slot)
    );

    seq_sched_table #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_tbl (
        .clk(clk), .rst(rst), .lock(running), .wr_en(tbl_we),
        .wr_idx(tbl_idx), .wr_ent(wr_ent), .rd_idx(slot), .rd_ent(ent)
    );

    for (genvar g = 0; g < NUM_PE; g++) begin : g_res
        assign res_arr[g] = pe_result[g*DATA_W +: DATA_W];
    end

    assign mem_we    = running && ent.valid && ent.is_wr;
    assign mem_re    = running && ent.valid && !ent.is_wr;
    assign mem_addr  = ent.addr;
    assign mem_wdata = res_arr[ent.pe];

    seq_operand_bank #(.DATA_W(DATA_W)) u_opr (
        .clk(clk), .rst(rst), .rd_fire(mem_re), .rd_pe(ent.pe),
        .mem_rdata(mem_rdata), .operand(pe_operand), .load(pe_load)
    );

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!mem_we && !mem_re));

endmodule

// File: tb/skew_mem_seq_tb.sv
module skew_mem_seq_tb;
    localparam int DW = 16;
    localparam int NS = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_start = 1'b0, stop = 1'b0, tbl_we = 1'b0;
    logic [5:0] tbl_idx = '0;
    logic tbl_valid = 1'b0, tbl_write = 1'b0;
    logic [1:0] tbl_pe = '0;
    logic [5:0] tbl_addr = '0;
    logic [4*DW-1:0] pe_result;
    logic [4*DW-1:0] pe_operand;
    logic [3:0] pe_load;
    logic [5:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic mem_we, mem_re;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    assign pe_result = {16'hA003, 16'hA002, 16'hA001, 16'hA000};

    skew_mem_seq u_dut (
        .clk(clk), .rst(rst), .sample_start(sample_start), .stop(stop),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
        .tbl_write(tbl_write), .tbl_pe(tbl_pe), .tbl_addr(tbl_addr),
        .pe_result(pe_result), .pe_operand(pe_operand), .pe_load(pe_load),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    logic [DW-1:0] mem [64];
    initial for (int i = 0; i < 64; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // {slot[5:0], valid, write, pe[1:0], addr[5:0]}
    localparam logic [15:0] VEC [8] = '{
        {6'd0,  1'b1, 1'b1, 2'd0, 6'd5},
        {6'd1,  1'b1, 1'b0, 2'd0, 6'd5},
        {6'd2,  1'b1, 1'b1, 2'd1, 6'd9},
        {6'd3,  1'b1, 1'b0, 2'd1, 6'd9},
        {6'd4,  1'b0, 1'b1, 2'd2, 6'd7},
        {6'd5,  1'b1, 1'b1, 2'd3, 6'd63},
        {6'd6,  1'b1, 1'b0, 2'd3, 6'd63},
        {6'd47, 1'b1, 1'b1, 2'd2, 6'd1}
    };

    logic       e_val [NS];
    logic       e_wr  [NS];
    logic [1:0] e_pe  [NS];
    logic [5:0] e_ad  [NS];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tbl_write_ent(input logic [5:0] idx, input logic v, input logic w,
                                 input logic [1:0] p, input logic [5:0] a);
        tbl_we = 1'b1; tbl_idx = idx; tbl_valid = v; tbl_write = w; tbl_pe = p; tbl_addr = a;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_start();
        sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    logic done = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            e_val[s] = 1'b0; e_wr[s] = 1'b0; e_pe[s] = '0; e_ad[s] = '0;
        end
        for (int v = 0; v < 8; v++) begin
            e_val[VEC[v][15:10]] = VEC[v][9];
            e_wr[VEC[v][15:10]]  = VEC[v][8];
            e_pe[VEC[v][15:10]]  = VEC[v][7:6];
            e_ad[VEC[v][15:10]]  = VEC[v][5:0];
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "mem_we", 32'(mem_we), 0);
        chk("R1", "mem_re", 32'(mem_re), 0);
        chk("R1", "pe_load", 32'(pe_load), 0);
        chk("R1", "pe_operand", 32'(pe_operand[31:0] | pe_operand[63:32]), 0);
        pulse_start();
        // R1: table is empty after reset, so a running slot 0 issues nothing
        chk("R1", "empty table we", 32'(mem_we), 0);
        chk("R1", "empty table re", 32'(mem_re), 0);
        pulse_stop();

        for (int v = 0; v < 8; v++)
            tbl_write_ent(VEC[v][15:10], VEC[v][9], VEC[v][8], VEC[v][7:6], VEC[v][5:0]);

        // R2 R3 R4 R5 R6 R7: walk 50 cycles (slot 0..47 then wrap to 0,1)
        pulse_start();
        for (int k = 0; k < NS + 2; k++) begin
            int s;
            logic [3:0] exp_load;
            s = k % NS;
            exp_load = '0;
            if (k >= 2 && e_val[(k-2) % NS] && !e_wr[(k-2) % NS])
                exp_load[e_pe[(k-2) % NS]] = 1'b1;
            chk("R4", $sformatf("we slot %0d", s), 32'(mem_we), 32'(e_val[s] && e_wr[s]));
            chk("R5", $sformatf("re slot %0d", s), 32'(mem_re), 32'(e_val[s] && !e_wr[s]));
            if (e_val[s]) chk("R4", $sformatf("addr slot %0d", s), 32'(mem_addr), 32'(e_ad[s]));
            if (e_val[s] && e_wr[s])
                chk("R6", $sformatf("wdata slot %0d", s), 32'(mem_wdata), 32'(16'hA000 + e_pe[s]));
            chk("R7", $sformatf("load idx %0d", k), 32'(pe_load), 32'(exp_load));
            @(negedge clk);
        end
        // R3 wrapped: slot 0 was checked again at k=48 above
        chk("R7", "operand pe0", 32'(pe_operand[15:0]), 32'h0000A000);
        chk("R7", "operand pe1", 32'(pe_operand[31:16]), 32'h0000A001);
        chk("R7", "operand pe2", 32'(pe_operand[47:32]), 32'h00000000);
        chk("R7", "operand pe3", 32'(pe_operand[63:48]), 32'h0000A003);

        // R9: stop silences strobes (now at slot 2, a write slot)
        pulse_stop();
        chk("R9", "we after stop", 32'(mem_we), 0);
        chk("R9", "re after stop", 32'(mem_re), 0);

        // R9: stop wins over simultaneous start
        sample_start = 1'b1; stop = 1'b1;
        @(negedge clk);
        sample_start = 1'b0; stop = 1'b0;
        chk("R9", "stop priority we", 32'(mem_we), 0);

        // R8: table write during a run is ignored
        pulse_start();
        tbl_write_ent(6'd0, 1'b0, 1'b0, 2'd0, 6'd0);
        pulse_stop();
        pulse_start();
        chk("R8", "slot0 kept we", 32'(mem_we), 1);
        chk("R8", "slot0 kept addr", 32'(mem_addr), 5);
        pulse_stop();

        // R8: table write while idle takes effect (slot 4 becomes W pe2 addr 7)
        tbl_write_ent(6'd4, 1'b1, 1'b1, 2'd2, 6'd7);
        pulse_start();
        repeat (4) @(negedge clk);
        chk("R8", "slot4 we", 32'(mem_we), 1);
        chk("R8", "slot4 addr", 32'(mem_addr), 7);
        chk("R6", "slot4 wdata", 32'(mem_wdata), 32'h0000A002);

        // R10: restart mid-run lands on slot 0
        pulse_start();
        chk("R10", "restart we", 32'(mem_we), 1);
        chk("R10", "restart addr", 32'(mem_addr), 5);
        @(negedge clk);
        chk("R2", "step to slot1 re", 32'(mem_re), 1);
        pulse_stop();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule